// File: doc/BRIEF.md
# DDR SDRAM Command Timing Guard

This block stands between a memory controller's command scheduler and the command pins of a DDR SDRAM. Every cycle it looks at the command the scheduler offers (an opcode and a bank number) and decides whether that command may go to the device in this clock without breaking a timing window. It keeps the windows for each bank (activate-to-column, activate-to-precharge minimum and maximum, activate-to-activate, precharge recovery, write recovery, auto-precharge recovery) and the device-wide ones (mode-set recovery, refresh recovery, bank-to-bank activate spacing, write-to-read turnaround).

The offered command is a valid/ready stream. `cmd_ready` reports, every cycle, whether the command now on `cmd_op`/`cmd_bank` is legal. A command issues only in a cycle where `cmd_valid` and `cmd_ready` are both high. When `cmd_valid` is high and `cmd_ready` is low, the command is refused: nothing in the guard changes, `viol_valid` is raised for that cycle with a code naming the first rule that blocks it, and the scheduler may keep offering the same command or swap in another. The guard also raises a refresh request once the refresh interval has run out since the last granted refresh, and a forced-precharge request for any bank left open for the maximum activate-to-precharge time.

All nanosecond limits are turned into clock counts at elaboration by dividing by the clock period (`TCK_PS`, picoseconds) and rounding up; `SPEED_GRADE` 0 picks the faster set (55 ns row cycle, 15 ns activate-to-column and precharge), 1 the slower set (60 ns, 18 ns). The auto-precharge write recovery equals the rounded write recovery plus the rounded precharge time. Below, Trc, Trcd and so on name these clock counts.

Top module: `sdram_cmd_guard`

## Requirements
- R1: While and right after reset, `refresh_req` is low, `force_pre` is all zero, `viol_valid` is low when nothing is offered, and every bank is idle.
- R2: `cmd_ready` is high exactly when the offered command breaks no rule; a refused offer (`cmd_valid` high, `cmd_ready` low) raises `viol_valid` that cycle with `viol_code` and changes no state. Rules are tested in this order: mode-set recovery (code 1), refresh recovery (code 2), then the command's own rules in the order given below.
- R3: Opcodes are 0 mode-set, 1 activate, 2 read, 3 write, 4 precharge, 5 read with auto-precharge, 6 write with auto-precharge, 7 refresh. Activate to an open bank, or a column command or precharge to an idle bank, or mode-set/refresh while any bank is open, is refused with code 3.
- R4: After a granted mode-set, no command is granted until Tmrd (2) cycles later (code 1).
- R5: Read, write and both auto-precharge forms to a bank are granted no earlier than Trcd cycles after its activate (code 7).
- R6: Activates to different banks are at least Trrd cycles apart (code 6).
- R7: Precharge waits for Tras-min cycles after the activate (code 9), then for Twr cycles after the last write to that bank (code 10).
- R8: Activate to an idle bank waits Trc cycles after its previous activate (code 4), then for its precharge recovery (code 5); a precharge starts Trp cycles of recovery.
- R9: Read with auto-precharge starts a recovery of (remaining Tras-min) + Trp cycles; write with auto-precharge starts (remaining Tras-min) + Tdal cycles; both are reported with code 5 and close the bank.
- R10: A read is granted no earlier than Twtr (2) cycles after any granted write (code 8).
- R11: After a granted refresh, nothing is granted for Trfc cycles (code 2); refresh also needs every bank past Trc and precharge recovery.
- R12: `refresh_req` rises exactly Trefi cycles after the last granted refresh and stays high until a refresh is granted.
- R13: `force_pre[b]` rises exactly Tras-max cycles after bank b's activate if the bank is still open, and stays high until the bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 3 | Command opcode (R3 encoding) |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| cmd_ready | output | 1 | The offered command is legal now |
| viol_valid | output | 1 | Offered command refused this cycle |
| viol_code | output | 4 | Rule that blocked the refused command |
| refresh_req | output | 1 | Refresh interval has run out |
| force_pre | output | NUM_BANKS | Per-bank request to close a bank held open too long |

## Verification
The case where two of the guard's duties meet is a pending refresh colliding with a bank that has been open for the maximum time: the refresh cannot be granted while that bank is open, so both requests are high together. The bench provokes it by granting a refresh, opening one bank right after the refresh recovery and leaving it open for the full maximum, then offering a refresh. It judges that both flags are up, that the refresh is refused with the bank-state code, that the precharge drops the forced-precharge flag one cycle later while the refresh request stays, and that the refresh is granted exactly after precharge recovery and then clears its request.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    OP_MRS = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_RDA = 3'd5,
    OP_WRA = 3'd6,
    OP_REF = 3'd7
  } cmd_op_e;

  typedef enum logic [3:0] {
    VC_NONE  = 4'd0,
    VC_MRD   = 4'd1,
    VC_RFC   = 4'd2,
    VC_STATE = 4'd3,
    VC_RC    = 4'd4,
    VC_RP    = 4'd5,
    VC_RRD   = 4'd6,
    VC_RCD   = 4'd7,
    VC_WTR   = 4'd8,
    VC_RAS   = 4'd9,
    VC_WR    = 4'd10
  } viol_code_e;

  // Per-bank summary handed to the rule checker.
  typedef struct packed {
    logic active;
    logic rc_ok;
    logic rp_ok;
    logic rcd_ok;
    logic ras_ok;
    logic wr_ok;
  } bank_stat_t;

  // Round a picosecond limit up to whole clocks.
  function automatic int ps_to_cyc(input longint ps, input longint tck);
    return int'((ps + tck - 1) / tck);
  endfunction

endpackage

// File: rtl/sdram_guard_dncnt.sv
module sdram_guard_dncnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/sdram_guard_bank.sv
module sdram_guard_bank
  import sdram_guard_pkg::*;
#(
  parameter int W       = 6,
  parameter int AW      = 15,
  parameter int TRAS_C  = 8,
  parameter int TRC_C   = 11,
  parameter int TRCD_C  = 3,
  parameter int TRP_C   = 3,
  parameter int TWR_C   = 3,
  parameter int TDAL_C  = 6,
  parameter int RASMX_C = 24000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  cmd_op_e    op,
  output bank_stat_t stat,
  output logic       force_pre
);

  logic          active_q;
  logic [AW-1:0] age_q;
  logic [W-1:0]  ras_cnt, rc_cnt, rcd_cnt, rp_cnt, wr_cnt;
  logic          act_ld, wr_ld, rp_ld, closing;
  logic [W-1:0]  rp_val;

  always_comb begin
    act_ld  = fire && (op == OP_ACT);
    wr_ld   = fire && (op == OP_WR || op == OP_WRA);
    closing = fire && (op == OP_PRE || op == OP_RDA || op == OP_WRA);
    rp_ld   = closing;
    case (op)
      OP_RDA:  rp_val = ras_cnt + W'(TRP_C - 1);
      OP_WRA:  rp_val = ras_cnt + W'(TDAL_C - 1);
      default: rp_val = W'(TRP_C - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_q <= 1'b0;
    else if (act_ld)  active_q <= 1'b1;
    else if (closing) active_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       age_q <= '0;
    else if (act_ld)                  age_q <= AW'(1);
    else if (!active_q)               age_q <= '0;
    else if (age_q != AW'(RASMX_C))   age_q <= age_q + 1'b1;
  end

  sdram_guard_dncnt #(.W(W)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_ld),
                                   .val(W'(TRAS_C - 1)), .cnt(ras_cnt));
  sdram_guard_dncnt #(.W(W)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act_ld),
                                   .val(W'(TRC_C - 1)), .cnt(rc_cnt));
  sdram_guard_dncnt #(.W(W)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_ld),
                                   .val(W'(TRCD_C - 1)), .cnt(rcd_cnt));
  sdram_guard_dncnt #(.W(W)) u_rp  (.clk(clk), .rst_n(rst_n), .load(rp_ld),
                                   .val(rp_val), .cnt(rp_cnt));
  sdram_guard_dncnt #(.W(W)) u_wr  (.clk(clk), .rst_n(rst_n), .load(wr_ld),
                                   .val(W'(TWR_C - 1)), .cnt(wr_cnt));

  always_comb begin
    stat.active = active_q;
    stat.rc_ok  = (rc_cnt == '0);
    stat.rp_ok  = (rp_cnt == '0);
    stat.rcd_ok = (rcd_cnt == '0);
    stat.ras_ok = (ras_cnt == '0);
    stat.wr_ok  = (wr_cnt == '0);
  end

  assign force_pre = active_q && (age_q >= AW'(RASMX_C));

endmodule

// File: rtl/sdram_guard_refresh.sv
module sdram_guard_refresh #(
  parameter int REFI_C = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_fire,
  output logic refresh_req
);

  localparam int RW = $clog2(REFI_C + 1);

  logic [RW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_q <= '0;
    else if (ref_fire)              since_q <= RW'(1);
    else if (since_q != RW'(REFI_C)) since_q <= since_q + 1'b1;
  end

  assign refresh_req = (since_q == RW'(REFI_C));

endmodule

// File: rtl/sdram_guard_rules.sv
module sdram_guard_rules
  import sdram_guard_pkg::*;
#(
  parameter int NB = 4
) (
  input  cmd_op_e                 op,
  input  logic [$clog2(NB)-1:0]   bank,
  input  bank_stat_t [NB-1:0]     stat,
  input  logic                    mrd_ok,
  input  logic                    rfc_ok,
  input  logic                    rrd_ok,
  input  logic                    wtr_ok,
  output logic                    legal,
  output viol_code_e              code
);

  bank_stat_t sel;
  logic       all_idle, all_rp_ok, all_rc_ok;

  always_comb begin
    all_idle  = 1'b1;
    all_rp_ok = 1'b1;
    all_rc_ok = 1'b1;
    for (int i = 0; i < NB; i++) begin
      all_idle  = all_idle  && !stat[i].active;
      all_rp_ok = all_rp_ok && stat[i].rp_ok;
      all_rc_ok = all_rc_ok && stat[i].rc_ok;
    end
  end

  always_comb begin
    sel  = stat[bank];
    code = VC_NONE;
    if (!mrd_ok)      code = VC_MRD;
    else if (!rfc_ok) code = VC_RFC;
    else begin
      case (op)
        OP_MRS, OP_REF: begin
          if (!all_idle)                     code = VC_STATE;
          else if (!all_rp_ok)               code = VC_RP;
          else if (op == OP_REF && !all_rc_ok) code = VC_RC;
        end
        OP_ACT: begin
          if (sel.active)      code = VC_STATE;
          else if (!sel.rc_ok) code = VC_RC;
          else if (!sel.rp_ok) code = VC_RP;
          else if (!rrd_ok)    code = VC_RRD;
        end
        OP_RD, OP_RDA: begin
          if (!sel.active)      code = VC_STATE;
          else if (!sel.rcd_ok) code = VC_RCD;
          else if (!wtr_ok)     code = VC_WTR;
        end
        OP_WR, OP_WRA: begin
          if (!sel.active)      code = VC_STATE;
          else if (!sel.rcd_ok) code = VC_RCD;
        end
        default: begin
          if (!sel.active)      code = VC_STATE;
          else if (!sel.ras_ok) code = VC_RAS;
          else if (!sel.wr_ok)  code = VC_WR;
        end
      endcase
    end
    legal = (code == VC_NONE);
  end

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int TCK_PS      = 5000,
  parameter int SPEED_GRADE = 0,
  parameter int NUM_BANKS   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic                         cmd_ready,
  output logic                         viol_valid,
  output logic [3:0]                   viol_code,
  output logic                         refresh_req,
  output logic [NUM_BANKS-1:0]         force_pre
);

  localparam longint TCK       = longint'(TCK_PS);
  localparam longint RC_PS     = (SPEED_GRADE == 0) ? 55000 : 60000;
  localparam longint RCD_PS    = (SPEED_GRADE == 0) ? 15000 : 18000;
  localparam longint RP_PS     = RCD_PS;
  localparam int TRAS_C  = ps_to_cyc(40000, TCK);
  localparam int RASMX_C = ps_to_cyc(120000000, TCK);
  localparam int TRC_C   = ps_to_cyc(RC_PS, TCK);
  localparam int TRFC_C  = ps_to_cyc(70000, TCK);
  localparam int TRCD_C  = ps_to_cyc(RCD_PS, TCK);
  localparam int TRP_C   = ps_to_cyc(RP_PS, TCK);
  localparam int TRRD_C  = ps_to_cyc(10000, TCK);
  localparam int TWR_C   = ps_to_cyc(15000, TCK);
  localparam int TDAL_C  = TWR_C + TRP_C;
  localparam int TMRD_C  = 2;
  localparam int TWTR_C  = 2;
  localparam int REFI_C  = ps_to_cyc(15600000, TCK);
  localparam int CW      = $clog2(TRAS_C + TDAL_C + TRC_C + TRFC_C + 1);
  localparam int AW      = $clog2(RASMX_C + 1);

  cmd_op_e                   op;
  viol_code_e                code;
  logic                      legal, fire;
  bank_stat_t [NUM_BANKS-1:0] stat;
  logic [CW-1:0]             mrd_cnt, rfc_cnt, rrd_cnt, wtr_cnt;

  assign op         = cmd_op_e'(cmd_op);
  assign cmd_ready  = legal;
  assign fire       = cmd_valid && legal;
  assign viol_valid = cmd_valid && !legal;
  assign viol_code  = cmd_valid ? code : VC_NONE;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdram_guard_bank #(
        .W(CW), .AW(AW), .TRAS_C(TRAS_C), .TRC_C(TRC_C), .TRCD_C(TRCD_C),
        .TRP_C(TRP_C), .TWR_C(TWR_C), .TDAL_C(TDAL_C), .RASMX_C(RASMX_C)
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .fire(fire && (cmd_bank == b)),
        .op(op), .stat(stat[b]), .force_pre(force_pre[b])
      );
    end
  endgenerate

  sdram_guard_dncnt #(.W(CW)) u_mrd (.clk(clk), .rst_n(rst_n),
    .load(fire && op == OP_MRS), .val(CW'(TMRD_C - 1)), .cnt(mrd_cnt));
  sdram_guard_dncnt #(.W(CW)) u_rfc (.clk(clk), .rst_n(rst_n),
    .load(fire && op == OP_REF), .val(CW'(TRFC_C - 1)), .cnt(rfc_cnt));
  sdram_guard_dncnt #(.W(CW)) u_rrd (.clk(clk), .rst_n(rst_n),
    .load(fire && op == OP_ACT), .val(CW'(TRRD_C - 1)), .cnt(rrd_cnt));
  sdram_guard_dncnt #(.W(CW)) u_wtr (.clk(clk), .rst_n(rst_n),
    .load(fire && (op == OP_WR || op == OP_WRA)), .val(CW'(TWTR_C - 1)),
    .cnt(wtr_cnt));

  sdram_guard_rules #(.NB(NUM_BANKS)) u_rules (
    .op(op), .bank(cmd_bank), .stat(stat),
    .mrd_ok(mrd_cnt == '0), .rfc_ok(rfc_cnt == '0),
    .rrd_ok(rrd_cnt == '0), .wtr_ok(wtr_cnt == '0),
    .legal(legal), .code(code)
  );

  sdram_guard_refresh #(.REFI_C(REFI_C)) u_refresh (
    .clk(clk), .rst_n(rst_n), .ref_fire(fire && op == OP_REF),
    .refresh_req(refresh_req)
  );

endmodule

// File: rtl/sdram_guard_chk.sv
module sdram_guard_chk
  import sdram_guard_pkg::*;
#(
  parameter int NB = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [2:0]            cmd_op,
  input logic [$clog2(NB)-1:0] cmd_bank,
  input logic                  viol_valid,
  input logic [3:0]            viol_code,
  input logic                  refresh_req,
  input logic [NB-1:0]         force_pre
);

  logic go;
  assign go = cmd_valid && cmd_ready;

  assert_refused_flagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (!cmd_ready && viol_code != 4'd0));

  assert_no_reopen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_ACT) |=> !(go && cmd_op == OP_ACT && cmd_bank == $past(cmd_bank)));

  assert_mrs_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_MRS) |=> !go);

  assert_ref_then_no_act_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_REF) |=> !(go && cmd_op == OP_ACT));

  assert_refresh_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !(go && cmd_op == OP_REF)) |=> refresh_req);

  assert_force_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((|force_pre) && !(go && (cmd_op == OP_PRE || cmd_op == OP_RDA || cmd_op == OP_WRA)))
      |=> (|force_pre));

endmodule

bind sdram_cmd_guard sdram_guard_chk #(.NB(NUM_BANKS)) u_guard_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_bank(cmd_bank), .viol_valid(viol_valid),
  .viol_code(viol_code), .refresh_req(refresh_req), .force_pre(force_pre)
);

// File: tb/tb_sdram_cmd_guard.sv
module tb_sdram_cmd_guard;

  localparam int TCK = 5000;
  function automatic int cyc(input int ps);
    return (ps + TCK - 1) / TCK;
  endfunction
  localparam int TRAS = cyc(40000), TRC = cyc(55000), TRFC = cyc(70000);
  localparam int TRCD = cyc(15000), TRP = cyc(15000), TRRD = cyc(10000);
  localparam int TWR = cyc(15000), TDAL = TWR + TRP, TMRD = 2, TWTR = 2;
  localparam int REFI = cyc(15600000), RASMX = cyc(120000000);

  localparam int MRS = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, RDA = 5, WRA = 6, REF = 7;
  localparam int C_MRD = 1, C_RFC = 2, C_ST = 3, C_RC = 4, C_RP = 5, C_RRD = 6;
  localparam int C_RCD = 7, C_WTR = 8, C_RAS = 9, C_WR = 10;

  logic       clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ready, viol_valid, refresh_req;
  logic [3:0] viol_code;
  logic [3:0] force_pre;
  int nvec = 0, nfail = 0;

  always #10 clk = ~clk;

  sdram_cmd_guard #(.TCK_PS(TCK), .SPEED_GRADE(0), .NUM_BANKS(4)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ready(cmd_ready), .viol_valid(viol_valid),
    .viol_code(viol_code), .refresh_req(refresh_req), .force_pre(force_pre));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; #1;
    check(refresh_req === 1'b0, "R1", "refresh_req", int'(refresh_req), 0);
    check(force_pre === 4'd0, "R1", "force_pre", int'(force_pre), 0);
    check(viol_valid === 1'b0, "R1", "viol_valid", int'(viol_valid), 0);
  endtask

  task automatic nop(input int n);
    repeat (n) begin @(negedge clk); cmd_valid = 1'b0; end
  endtask

  task automatic try_cmd(input int op, input int bank, input bit go,
                         input int code, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_bank = 2'(bank); #1;
    check(cmd_ready === go && viol_valid === !go, req, "grant",
          int'(cmd_ready), int'(go));
    if (!go) check(viol_code === 4'(code), req, "code", int'(viol_code), code);
  endtask

  task automatic issue(input int op, input int bank, input string req);
    try_cmd(op, bank, 1'b1, 0, req);
  endtask

  task automatic sweep(input int op, input int bank, input int n,
                       input int code, input string req);
    for (int g = 1; g <= n; g++) try_cmd(op, bank, g == n, code, req);
  endtask

  // Activate after a close issued rel cycles after the bank's activate.
  task automatic sweep_act(input int bank, input int rel, input int n_rp,
                           input string req);
    int n;
    n = (TRC - rel > n_rp) ? TRC - rel : n_rp;
    for (int g = 1; g <= n; g++)
      try_cmd(ACT, bank, g == n, (rel + g < TRC) ? C_RC : C_RP, req);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    // R3 bank-state rules on every bank
    for (int b = 0; b < 4; b++) begin
      do_reset();
      try_cmd(RD, b, 1'b0, C_ST, "R3");
      try_cmd(PRE, b, 1'b0, C_ST, "R3");
      try_cmd(WRA, b, 1'b0, C_ST, "R3");
      issue(ACT, b, "R3");
      try_cmd(ACT, b, 1'b0, C_ST, "R3");
      try_cmd(REF, 0, 1'b0, C_ST, "R3");
      try_cmd(MRS, 0, 1'b0, C_ST, "R3");
    end
    // R4 mode-set recovery
    do_reset(); issue(MRS, 0, "R4"); sweep(ACT, 2, TMRD, C_MRD, "R4");
    // R5 activate-to-column for every bank and column op
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        do_reset(); issue(ACT, b, "R5");
        sweep((k == 0) ? RD : (k == 1) ? WR : (k == 2) ? RDA : WRA, b, TRCD, C_RCD, "R5");
      end
    end
    // R6 activate spacing between banks
    for (int b = 1; b < 4; b++) begin
      do_reset(); issue(ACT, 0, "R6"); sweep(ACT, b, TRRD, C_RRD, "R6");
    end
    // R7 tRAS then R8 row cycle overlapping precharge recovery
    do_reset(); issue(ACT, 0, "R7"); sweep(PRE, 0, TRAS, C_RAS, "R7");
    sweep_act(0, TRAS, TRP, "R8");
    // R8 precharge recovery alone
    do_reset(); issue(ACT, 0, "R8"); nop(TRC); issue(PRE, 0, "R8");
    sweep_act(0, TRC + 1, TRP, "R8");
    // R7 write recovery before precharge
    do_reset(); issue(ACT, 0, "R7"); nop(TRAS); issue(WR, 0, "R7");
    sweep(PRE, 0, TWR, C_WR, "R7");
    // R10 write-to-read, other bank then same bank
    do_reset(); issue(ACT, 0, "R10"); nop(TRRD - 1); issue(ACT, 1, "R10");
    nop(TRCD); issue(WR, 0, "R10"); sweep(RD, 1, TWTR, C_WTR, "R10");
    issue(WR, 0, "R10"); sweep(RD, 0, TWTR, C_WTR, "R10");
    // R9 auto-precharge recoveries
    do_reset(); issue(ACT, 0, "R9"); nop(TRAS - 1); issue(WRA, 0, "R9");
    sweep_act(0, TRAS, TDAL, "R9");
    do_reset(); issue(ACT, 0, "R9"); nop(TRCD - 1); issue(WRA, 0, "R9");
    sweep_act(0, TRCD, TDAL + TRAS - TRCD, "R9");
    do_reset(); issue(ACT, 1, "R9"); sweep(RDA, 1, TRCD, C_RCD, "R9");
    sweep_act(1, TRCD, TRP + TRAS - TRCD, "R9");
    // R11 refresh recovery
    do_reset(); issue(REF, 0, "R11"); sweep(ACT, 3, TRFC, C_RFC, "R11");
    do_reset(); issue(REF, 0, "R11"); sweep(REF, 0, TRFC, C_RFC, "R11");
    // R12 refresh interval
    nop(REFI - 1); #1;
    check(refresh_req === 1'b0, "R12", "early refresh_req", int'(refresh_req), 0);
    nop(1); #1;
    check(refresh_req === 1'b1, "R12", "refresh_req", int'(refresh_req), 1);
    nop(5); #1;
    check(refresh_req === 1'b1, "R12", "held refresh_req", int'(refresh_req), 1);
    issue(REF, 0, "R12"); nop(1); #1;
    check(refresh_req === 1'b0, "R12", "cleared refresh_req", int'(refresh_req), 0);
    // R13 forced precharge colliding with a pending refresh
    do_reset(); issue(REF, 0, "R13"); nop(TRFC - 1); issue(ACT, 2, "R13");
    nop(RASMX - 1); #1;
    check(force_pre === 4'd0, "R13", "early force_pre", int'(force_pre), 0);
    check(refresh_req === 1'b1, "R12", "refresh_req", int'(refresh_req), 1);
    nop(1); #1;
    check(force_pre === 4'b0100, "R13", "force_pre", int'(force_pre), 4);
    try_cmd(REF, 0, 1'b0, C_ST, "R13");
    issue(PRE, 2, "R13");
    @(negedge clk); cmd_valid = 1'b0; #1;
    check(force_pre === 4'd0, "R13", "cleared force_pre", int'(force_pre), 0);
    check(refresh_req === 1'b1, "R12", "refresh_req kept", int'(refresh_req), 1);
    sweep(REF, 0, TRP - 1, C_RP, "R11");
    nop(1); #1;
    check(refresh_req === 1'b0, "R12", "refresh_req after REF", int'(refresh_req), 0);
    // R2 refused offers left no trace: a fresh activate is still legal
    try_cmd(ACT, 2, 1'b0, C_RFC, "R2");
    nop(TRFC - 2);
    issue(ACT, 2, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule